// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN message identifier is wanted. It holds eight acceptance-code bytes and eight mask bytes. Each group of eight is split into two banks of four bytes. Software reaches these bytes through a byte-wide register port. A received identifier arrives as a 32-bit word of four identifier bytes. The filter compares each identifier bit with the code bit in the same position. Where the mask marks a bit as don't-care, that bit is left out of the comparison. The result is a hit flag and the index of the matching filter.

The block has two modes. In 32-bit mode the two banks act as two filters, and each filter compares all four identifier bytes. In 16-bit mode the code and mask bytes pair up into four filters, and each of these compares identifier bytes 0 and 1 only. The code bytes, the mask bytes and the mode can change only while the controller is in initialization mode. Initialization mode means that both the request flag and the acknowledge flag are high.

Identifiers enter on a valid/ready port. `id_ready` is high whenever the block is outside initialization mode. An identifier counts as accepted only in a cycle where both `id_valid` and `id_ready` are high. A sender that sees `id_ready` low must hold its identifier until ready returns. The result side carries no back-pressure: `res_valid` pulses for one cycle per accepted identifier.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, every code byte and every mask byte reads back as 0. The result outputs `res_valid`, `res_hit` and `res_idx` are 0, and the mode is 32-bit.
- R2: A write (`reg_wr`=1) takes effect only when `init_req` and `init_ack` are both 1. A write at any other time leaves the addressed byte unchanged.
- R3: `reg_rdata` always shows the byte selected by `reg_mask_sel` (0 selects code, 1 selects mask) and `reg_addr` (byte 0 to 7), in the same cycle, in any mode.
- R4: A mask bit of 1 makes that identifier bit don't-care. A mask bit of 0 requires the identifier bit to equal the code bit in the same position. Identifier byte n sits on `id_data[8n+7:8n]`.
- R5: In 32-bit mode, filter 0 uses code and mask bytes 0 to 3 against identifier bytes 0 to 3. Filter 1 uses bytes 4 to 7 against identifier bytes 0 to 3. When both filters match, the reported index is 0.
- R6: In 16-bit mode, filter f (0 to 3) uses code and mask bytes 2f and 2f+1 against identifier bytes 0 and 1. Identifier bytes 2 and 3 are ignored. The lowest matching index is reported.
- R7: The block takes `mode16` (1 selects 16-bit mode) only while in initialization mode. Outside initialization mode, a change on `mode16` has no effect on filtering.
- R8: `res_valid`, `res_hit` and `res_idx` are registered. They are due one clock after the accepting edge. `res_valid` is high for exactly that one cycle. `res_hit` and `res_idx` hold until the next accepted identifier.
- R9: When no filter matches, `res_hit` is 0 and `res_idx` is 0.
- R10: `id_ready` is 0 while in initialization mode. An identifier presented then produces no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_req | input | 1 | Initialization request flag |
| init_ack | input | 1 | Initialization acknowledge flag |
| mode16 | input | 1 | Filter mode select: 1 selects 16-bit, 0 selects 32-bit |
| reg_wr | input | 1 | Register write strobe |
| reg_mask_sel | input | 1 | Register bank select: 0 selects code, 1 selects mask |
| reg_addr | input | 3 | Byte index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected byte |
| id_valid | input | 1 | Identifier valid |
| id_ready | output | 1 | Identifier ready |
| id_data | input | 32 | Identifier bytes 0 to 3, with byte n on bits 8n+7:8n |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A filter matched |
| res_idx | output | 2 | Index of the matching filter |

## Verification
A register write is due at the edge on which it is presented, and its readback is checked half a cycle later. A mode change made during initialization needs one edge before the block uses it. Filter results are due one edge after the accepting edge. The bench drives each input on a falling edge and samples the result on the next falling edge. It checks that `res_valid` drops again on the falling edge that follows. It also checks that strobes offered while ready is low leave `res_valid` low on the following falling edge.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 8;
  localparam int N_BANKS = 2;
  localparam int ID_BYTES = N_BYTES / N_BANKS;
  localparam int N_F16   = N_BYTES / 2;
  localparam int IDX_W   = $clog2(N_F16);
  localparam int ADDR_W  = $clog2(N_BYTES);
  typedef logic [N_BYTES-1:0][BYTE_W-1:0] byte_arr_t;
  typedef logic [ID_BYTES-1:0][BYTE_W-1:0] id_arr_t;
endpackage

// File: rtl/can_filt_regs.sv
module can_filt_regs
  import can_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_on,
  input  logic              wr_en,
  input  logic              wr_mask,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              mode_in,
  output logic [BYTE_W-1:0] rd_data,
  output byte_arr_t         code_o,
  output byte_arr_t         mask_o,
  output logic              mode_o
);
  byte_arr_t code_q, mask_q;
  logic      mode_q;
  logic      wr_ok;

  assign wr_ok = wr_en && init_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (init_on) mode_q <= mode_in;
      if (wr_ok && !wr_mask) code_q[addr] <= wr_data;
      if (wr_ok &&  wr_mask) mask_q[addr] <= wr_data;
    end
  end

  assign rd_data = wr_mask ? mask_q[addr] : code_q[addr];
  assign code_o  = code_q;
  assign mask_o  = mask_q;
  assign mode_o  = mode_q;

  a_r2_no_write_outside_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_on |=> ($stable(code_q) && $stable(mask_q)));
  a_r7_mode_held_outside_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_on |=> $stable(mode_q));
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
  import can_filt_pkg::*;
(
  input  byte_arr_t         code,
  input  byte_arr_t         mask,
  input  id_arr_t           id,
  input  logic              mode16,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [N_BYTES-1:0] ok32, ok16;
  logic [N_BANKS-1:0] bank_hit;
  logic [N_F16-1:0]   f16_hit;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    localparam int J32 = k % ID_BYTES;
    localparam int J16 = k % 2;
    assign ok32[k] = &((id[J32] ~^ code[k]) | mask[k]);
    assign ok16[k] = &((id[J16] ~^ code[k]) | mask[k]);
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_hit[b] = &ok32[b*ID_BYTES +: ID_BYTES];
  end

  for (genvar f = 0; f < N_F16; f++) begin : g_f16
    assign f16_hit[f] = &ok16[2*f +: 2];
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    if (mode16) begin
      for (int f = N_F16 - 1; f >= 0; f--) begin
        if (f16_hit[f]) begin
          hit = 1'b1;
          idx = IDX_W'(f);
        end
      end
    end else begin
      for (int b = N_BANKS - 1; b >= 0; b--) begin
        if (bank_hit[b]) begin
          hit = 1'b1;
          idx = IDX_W'(b);
        end
      end
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_filt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_req,
  input  logic        init_ack,
  input  logic        mode16,
  input  logic        reg_wr,
  input  logic        reg_mask_sel,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        id_valid,
  output logic        id_ready,
  input  logic [31:0] id_data,
  output logic        res_valid,
  output logic        res_hit,
  output logic [1:0]  res_idx
);
  logic      init_on;
  byte_arr_t code_w, mask_w;
  logic      mode_w;
  logic      m_hit;
  logic [IDX_W-1:0] m_idx;
  logic      take;

  assign init_on  = init_req && init_ack;
  assign id_ready = !init_on;
  assign take     = id_valid && id_ready;

  can_filt_regs i_regs (
    .clk(clk), .rst_n(rst_n), .init_on(init_on),
    .wr_en(reg_wr), .wr_mask(reg_mask_sel), .addr(reg_addr),
    .wr_data(reg_wdata), .mode_in(mode16), .rd_data(reg_rdata),
    .code_o(code_w), .mask_o(mask_w), .mode_o(mode_w)
  );

  can_filt_match i_match (
    .code(code_w), .mask(mask_w), .id(id_arr_t'(id_data)),
    .mode16(mode_w), .hit(m_hit), .idx(m_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= take;
      if (take) begin
        res_hit <= m_hit;
        res_idx <= m_idx;
      end
    end
  end

  a_r8_result_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> res_valid);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !res_valid);
  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(res_hit) && $stable(res_idx)));
  a_r9_idx_zero_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_idx == 2'd0));
  a_r10_no_result_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    init_on |=> !res_valid);
  a_r5_two_filters_in_32: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !mode_w) |=> !res_idx[1]);
endmodule

// File: tb/test_can_accept_filter.sv
module test_can_accept_filter;
  logic clk = 0, rst_n = 0;
  logic init_req = 0, init_ack = 0, mode16 = 0;
  logic reg_wr = 0, reg_mask_sel = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic id_valid = 0, id_ready;
  logic [31:0] id_data = 0;
  logic res_valid, res_hit;
  logic [1:0] res_idx;

  int errors = 0, checks = 0;
  logic [7:0] m_code [8];
  logic [7:0] m_mask [8];
  logic m_mode = 0;

  always #2 clk = ~clk;

  can_accept_filter i_can_accept_filter (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic byte_ok(logic [7:0] idb, logic [7:0] c, logic [7:0] m);
    return ((idb ~^ c) | m) == 8'hFF;
  endfunction

  function automatic logic [2:0] model(logic [31:0] id);
    logic [7:0] b [4];
    for (int n = 0; n < 4; n++) b[n] = id[8*n +: 8];
    if (m_mode) begin
      for (int f = 0; f < 4; f++)
        if (byte_ok(b[0], m_code[2*f], m_mask[2*f]) && byte_ok(b[1], m_code[2*f+1], m_mask[2*f+1]))
          return {1'b1, 2'(f)};
    end else begin
      for (int k = 0; k < 2; k++) begin
        logic ok = 1'b1;
        for (int n = 0; n < 4; n++) ok &= byte_ok(b[n], m_code[4*k+n], m_mask[4*k+n]);
        if (ok) return {1'b1, 2'(k)};
      end
    end
    return 3'b000;
  endfunction

  task automatic set_init(logic on);
    @(negedge clk); init_req = on; init_ack = on;
    @(negedge clk);
  endtask

  task automatic wr(logic ms, int a, logic [7:0] d, logic in_init);
    @(negedge clk);
    reg_wr = 1; reg_mask_sel = ms; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (in_init) begin
      if (ms) m_mask[a] = d; else m_code[a] = d;
    end
  endtask

  task automatic rd_chk(string req, logic ms, int a);
    reg_mask_sel = ms; reg_addr = 3'(a);
    #1;
    chk(req, reg_rdata, ms ? m_mask[a] : m_code[a]);
  endtask

  task automatic send(string req, logic [31:0] id);
    logic [2:0] e;
    e = model(id);
    @(negedge clk); id_valid = 1; id_data = id;
    @(negedge clk); id_valid = 0;
    chk({req, " valid"}, res_valid, 1);
    chk({req, " hit"}, res_hit, e[2]);
    chk({req, " idx"}, res_idx, e[1:0]);
    @(negedge clk);
    chk("R8 pulse ends", res_valid, 0);
  endtask

  task automatic config_rand(logic md);
    set_init(1);
    mode16 = md;
    for (int a = 0; a < 8; a++) begin
      wr(0, a, 8'($urandom), 1);
      wr(1, a, 8'($urandom) & 8'($urandom), 1);
    end
    @(negedge clk); m_mode = md;
    set_init(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int a = 0; a < 8; a++) begin m_code[a] = 0; m_mask[a] = 0; end
    #1;
    chk("R1 res_valid", res_valid, 0);
    chk("R1 res_hit", res_hit, 0);
    chk("R1 res_idx", res_idx, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) begin rd_chk("R1 code", 0, a); rd_chk("R1 mask", 1, a); end
    // R1: mode is 32-bit, so an all-zero id hits filter 0
    send("R1 mode32 zero id", 32'h0);
    chk("R1 idx0", res_idx, 0);

    // R2: writes outside init ignored
    wr(0, 3, 8'hA5, 0); rd_chk("R2 code ignored", 0, 3);
    init_req = 1; wr(1, 6, 8'h5A, 0); rd_chk("R2 req only ignored", 1, 6); init_req = 0;
    init_ack = 1; wr(1, 2, 8'h3C, 0); rd_chk("R2 ack only ignored", 1, 2); init_ack = 0;

    // R3, R4, R5 directed: bank0 exact id, bank1 all don't-care
    set_init(1);
    mode16 = 0;
    wr(0, 0, 8'h11, 1); wr(0, 1, 8'h22, 1); wr(0, 2, 8'h33, 1); wr(0, 3, 8'h44, 1);
    for (int a = 4; a < 8; a++) wr(1, a, 8'hFF, 1);
    rd_chk("R3 read in init", 0, 2);
    // R10: not ready in init, strobe ignored
    chk("R10 ready low", id_ready, 0);
    @(negedge clk); id_valid = 1; id_data = 32'h44332211;
    @(negedge clk); id_valid = 0;
    chk("R10 no result", res_valid, 0);
    set_init(0);
    chk("R10 ready high", id_ready, 1);
    rd_chk("R3 read outside init", 0, 1);
    send("R5 both match prio0", 32'h44332211);
    chk("R5 idx0", res_idx, 0);
    send("R5 bank1 only", 32'h44332210);
    chk("R5 idx1", res_idx, 1);

    // R4/R9: no match case
    set_init(1);
    wr(1, 4, 8'h00, 1); wr(0, 4, 8'h99, 1);
    // R4: mask low 3 bits of byte 1 don't-care
    wr(1, 1, 8'h07, 1);
    set_init(0);
    send("R9 no match", 32'h44332210);
    chk("R9 hit0", res_hit, 0); chk("R9 idx0", res_idx, 0);
    send("R4 masked bits", 32'h44332511);
    chk("R4 hit", res_hit, 1);
    send("R4 unmasked bit", 32'h44332A11);

    // R6: 16-bit mode, bytes 2/3 ignored
    set_init(1);
    mode16 = 1;
    for (int a = 0; a < 8; a++) begin wr(0, a, 8'(a + 1), 1); wr(1, a, 8'h00, 1); end
    @(negedge clk); m_mode = 1;
    set_init(0);
    send("R6 filter2", 32'hDEAD0605);
    chk("R6 idx2", res_idx, 2);
    send("R6 filter0 ignores high", 32'h00000201);
    // R7: mode16 change outside init has no effect
    mode16 = 0;
    @(negedge clk);
    send("R7 mode held", 32'hFFFF0807);
    chk("R7 idx3", res_idx, 3);

    // R8: hit/idx hold while idle
    repeat (3) @(negedge clk);
    chk("R8 hold hit", res_hit, 1); chk("R8 hold idx", res_idx, 3);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      config_rand(r[0]);
      for (int i = 0; i < 40; i++) begin
        logic [31:0] id;
        int k;
        k = $urandom_range(0, 7);
        id = $urandom;
        if (i % 2 == 0) begin
          for (int n = 0; n < 4; n++) begin
            int src;
            src = m_mode ? ((k & 6) + (n % 2)) : ((k & 4) + n);
            id[8*n +: 8] = (m_code[src] & ~m_mask[src]) | (8'($urandom) & m_mask[src]);
          end
        end
        send(m_mode ? "R6 random" : "R5 random", id);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule